// File: doc/BRIEF.md
# Queued Command Dispatcher with Occupancy Interrupts

This block sits between a processor's register interface and a serial-bus master engine. Command and data words written by software go into an eight-entry write queue. A return path collects bytes that the engine reads off the bus into an eight-entry read queue, and software drains that queue one byte at a time. The engine takes commands through a valid/ready handshake. It hands back read bytes with a single-cycle valid strobe.

When the queued setting is off, every stored word goes to the engine as soon as the engine is free. When the queued setting is on, words pile up until software raises the run control. They then leave strictly in arrival order. Lowering run stops further dispatch only at a command boundary: a word already offered to the engine stays offered until the engine accepts it.

Each queue has a clear pulse and an occupancy threshold that drives a level interrupt. The read-side interrupt fires when occupancy is at or above its threshold, and an enable bit gates it. The write-side interrupt fires when occupancy is at or below its threshold. Software clears either condition by servicing the queue.

Top module: `cq_ctrl`

## Requirements
- R1: While `rst` is high, both counts are 0, both empty flags are 1, both full flags are 0, all sticky flags are 0, `eng_cmd_valid` is 0, `host_rd_valid` is 0 and both interrupts are 0.
- R2: With `cfg_queued` = 0, a word written at clock edge k is offered on `eng_cmd_valid`/`eng_cmd_word` after edge k+1, whatever `cfg_run` is.
- R3: With `cfg_queued` = 1 and `cfg_run` = 0, written words accumulate in the write queue (`wq_count` rises by one per accepted write) and nothing is offered to the engine.
- R4: With dispatch allowed, words reach the engine in write order, one per accepted handshake. While `eng_cmd_valid` is high and `eng_cmd_ready` is low, `eng_cmd_word` holds steady.
- R5: If `cfg_run` falls while a word is offered, that word stays offered until accepted. No further word is offered until `cfg_run` returns to 1.
- R6: The write queue holds `WQ_DEPTH` (8) words. A write while full is dropped, sets the sticky `wq_ovf`, and leaves the stored words and their order intact.
- R7: An `eng_ret_valid` strobe stores `eng_ret_byte` in the read queue. A `host_rd_en` pop on a non-empty queue raises `host_rd_valid` after the next edge, with the oldest byte on `host_rd_byte`.
- R8: A return strobe into a full read queue is dropped and sets the sticky `rq_ovf`. A pop from an empty read queue is dropped and sets the sticky `rq_unf`.
- R9: `rq_irq` is registered. After each edge it equals `cfg_rd_irq_en` AND (`rq_count` >= `cfg_rd_thresh`), using the values before that edge. A threshold of 0 therefore always fires when enabled.
- R10: `wq_irq` is registered. After each edge it equals (`wq_count` <= `cfg_wr_thresh`), using the values before that edge. It has no enable, and a threshold of 0 means the queue is empty.
- R11: A `ctl_wr_clear` or `ctl_rd_clear` pulse empties its queue and resets that queue's sticky flags. It wins over a push or pop in the same cycle, so no sticky flag is set and no `host_rd_valid` is produced. A write clear does not withdraw the word already offered to the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_queued | input | 1 | 1: hold words until run; 0: dispatch at once |
| cfg_run | input | 1 | Run/stop for queued dispatch |
| cfg_rd_irq_en | input | 1 | Enable for the read-queue interrupt |
| cfg_rd_thresh | input | $clog2(RQ_DEPTH) | Read threshold, 0..7 |
| cfg_wr_thresh | input | $clog2(WQ_DEPTH+1) | Write threshold, 0..8 |
| ctl_wr_clear | input | 1 | Pulse: empty write queue |
| ctl_rd_clear | input | 1 | Pulse: empty read queue |
| host_wr_en | input | 1 | Store one command/data word |
| host_wr_word | input | CMD_W | Word to store |
| host_rd_en | input | 1 | Pop one returned byte |
| host_rd_byte | output | RET_W | Popped byte |
| host_rd_valid | output | 1 | `host_rd_byte` carries a popped byte |
| eng_cmd_valid | output | 1 | A word is offered to the engine |
| eng_cmd_word | output | CMD_W | Offered word |
| eng_cmd_ready | input | 1 | Engine accepts the offered word |
| eng_ret_valid | input | 1 | Engine returns one byte |
| eng_ret_byte | input | RET_W | Returned byte |
| wq_count | output | $clog2(WQ_DEPTH+1) | Words waiting in the write queue |
| rq_count | output | $clog2(RQ_DEPTH+1) | Bytes held in the read queue |
| wq_full | output | 1 | Write queue full |
| wq_empty | output | 1 | Write queue empty |
| rq_full | output | 1 | Read queue full |
| rq_empty | output | 1 | Read queue empty |
| wq_ovf | output | 1 | Sticky: write dropped on full |
| rq_ovf | output | 1 | Sticky: return byte dropped on full |
| rq_unf | output | 1 | Sticky: pop on empty |
| rq_irq | output | 1 | Read occupancy interrupt |
| wq_irq | output | 1 | Write occupancy interrupt |

## Verification
The bench sweeps every threshold against every occupancy from 0 to 8 for both interrupts. A swapped or off-by-one compare would fire at exactly one wrong count, and this sweep exposes it. It lowers run while a word is stalled at the engine: a design that treats stop as immediate would drop or retract that word, and a design that ignores stop would offer the next one. It clears the write queue while a word is offered, and clears the read queue while a push and a pop arrive in the same cycle. A design with the wrong priority would leave a stray byte or a set sticky flag, or would withdraw the in-flight command. It also fills both queues one past full. A queue that wraps would corrupt the order of the drained words.

// File: rtl/cq_pkg.sv
package cq_pkg;
  // Direction of an occupancy comparison against a threshold
  typedef enum logic {
    CMP_AT_LEAST = 1'b0,
    CMP_AT_MOST  = 1'b1
  } cmp_dir_e;
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          pop_ok,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  // Storage and read port without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
    if (pop_ok)  rdata     <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (push && full) ovf <= 1'b1;
      if (pop && empty) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/cq_dispatch.sv
module cq_dispatch (
  input  logic clk,
  input  logic rst,
  input  logic queued,
  input  logic run,
  input  logic fifo_empty,
  input  logic pop_ok,
  input  logic eng_ready,
  output logic pop_req,
  output logic stage_valid
);
  logic go;

  // Direct mode always dispatches; queued mode waits for run.
  assign go      = !queued || run;
  // A new word is fetched only at a command boundary.
  assign pop_req = go && !fifo_empty && (!stage_valid || eng_ready);

  always_ff @(posedge clk) begin
    if (rst)            stage_valid <= 1'b0;
    else if (pop_ok)    stage_valid <= 1'b1;
    else if (eng_ready) stage_valid <= 1'b0;
  end
endmodule

// File: rtl/cq_irq.sv
module cq_irq
  import cq_pkg::*;
#(
  parameter int       CW  = 4,
  parameter cmp_dir_e DIR = CMP_AT_LEAST
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thresh,
  output logic          irq
);
  logic hit;

  generate
    if (DIR == CMP_AT_LEAST) begin : g_ge
      assign hit = (count >= thresh);
    end else begin : g_le
      assign hit = (count <= thresh);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en && hit;
  end
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int CMD_W    = 16,
  parameter int RET_W    = 8,
  parameter int WQ_DEPTH = 8,
  parameter int RQ_DEPTH = 8,
  localparam int WCW     = $clog2(WQ_DEPTH + 1),
  localparam int RCW     = $clog2(RQ_DEPTH + 1),
  localparam int RTW     = $clog2(RQ_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_queued,
  input  logic             cfg_run,
  input  logic             cfg_rd_irq_en,
  input  logic [RTW-1:0]   cfg_rd_thresh,
  input  logic [WCW-1:0]   cfg_wr_thresh,
  input  logic             ctl_wr_clear,
  input  logic             ctl_rd_clear,
  input  logic             host_wr_en,
  input  logic [CMD_W-1:0] host_wr_word,
  input  logic             host_rd_en,
  output logic [RET_W-1:0] host_rd_byte,
  output logic             host_rd_valid,
  output logic             eng_cmd_valid,
  output logic [CMD_W-1:0] eng_cmd_word,
  input  logic             eng_cmd_ready,
  input  logic             eng_ret_valid,
  input  logic [RET_W-1:0] eng_ret_byte,
  output logic [WCW-1:0]   wq_count,
  output logic [RCW-1:0]   rq_count,
  output logic             wq_full,
  output logic             wq_empty,
  output logic             rq_full,
  output logic             rq_empty,
  output logic             wq_ovf,
  output logic             rq_ovf,
  output logic             rq_unf,
  output logic             rq_irq,
  output logic             wq_irq
);
  logic wq_pop_req, wq_pop_ok, wq_unf;
  logic rq_pop_ok;

  cq_fifo #(.W(CMD_W), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst(rst), .clr(ctl_wr_clear),
    .push(host_wr_en), .wdata(host_wr_word),
    .pop(wq_pop_req), .rdata(eng_cmd_word), .pop_ok(wq_pop_ok),
    .count(wq_count), .full(wq_full), .empty(wq_empty),
    .ovf(wq_ovf), .unf(wq_unf)
  );

  cq_dispatch u_disp (
    .clk(clk), .rst(rst), .queued(cfg_queued), .run(cfg_run),
    .fifo_empty(wq_empty), .pop_ok(wq_pop_ok), .eng_ready(eng_cmd_ready),
    .pop_req(wq_pop_req), .stage_valid(eng_cmd_valid)
  );

  cq_fifo #(.W(RET_W), .DEPTH(RQ_DEPTH)) u_rq (
    .clk(clk), .rst(rst), .clr(ctl_rd_clear),
    .push(eng_ret_valid), .wdata(eng_ret_byte),
    .pop(host_rd_en), .rdata(host_rd_byte), .pop_ok(rq_pop_ok),
    .count(rq_count), .full(rq_full), .empty(rq_empty),
    .ovf(rq_ovf), .unf(rq_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rd_valid <= 1'b0;
    else     host_rd_valid <= rq_pop_ok;
  end

  cq_irq #(.CW(RCW), .DIR(CMP_AT_LEAST)) u_rirq (
    .clk(clk), .rst(rst), .en(cfg_rd_irq_en),
    .count(rq_count), .thresh(RCW'(cfg_rd_thresh)), .irq(rq_irq)
  );

  cq_irq #(.CW(WCW), .DIR(CMP_AT_MOST)) u_wirq (
    .clk(clk), .rst(rst), .en(1'b1),
    .count(wq_count), .thresh(cfg_wr_thresh), .irq(wq_irq)
  );
endmodule

// File: rtl/cq_ctrl_chk.sv
module cq_ctrl_chk #(
  parameter int CMD_W    = 16,
  parameter int WQ_DEPTH = 8,
  parameter int RQ_DEPTH = 8,
  localparam int WCW     = $clog2(WQ_DEPTH + 1),
  localparam int RCW     = $clog2(RQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_queued,
  input logic             cfg_run,
  input logic             cfg_rd_irq_en,
  input logic             ctl_wr_clear,
  input logic             ctl_rd_clear,
  input logic             host_wr_en,
  input logic             host_rd_en,
  input logic             eng_cmd_valid,
  input logic             eng_cmd_ready,
  input logic [CMD_W-1:0] eng_cmd_word,
  input logic [WCW-1:0]   wq_count,
  input logic [RCW-1:0]   rq_count,
  input logic             wq_full,
  input logic             rq_empty,
  input logic             wq_ovf,
  input logic             wq_unf,
  input logic             rq_unf,
  input logic             rq_irq
);
  a_r4_hold_word: assert property (@(posedge clk) disable iff (rst)
    eng_cmd_valid && !eng_cmd_ready |=> eng_cmd_valid && $stable(eng_cmd_word));

  a_r3_no_dispatch: assert property (@(posedge clk) disable iff (rst)
    cfg_queued && !cfg_run && !eng_cmd_valid |=> !eng_cmd_valid);

  a_r6_overflow: assert property (@(posedge clk) disable iff (rst)
    host_wr_en && wq_full && !ctl_wr_clear |=> wq_ovf);

  a_r6_no_wq_underflow: assert property (@(posedge clk) disable iff (rst)
    !wq_unf);

  a_r8_underflow: assert property (@(posedge clk) disable iff (rst)
    host_rd_en && rq_empty && !ctl_rd_clear |=> rq_unf);

  a_r11_wr_clear: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_clear |=> wq_count == '0 && !wq_ovf);

  a_r11_rd_clear: assert property (@(posedge clk) disable iff (rst)
    ctl_rd_clear |=> rq_count == '0 && !rq_unf);

  a_r9_gate: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_irq_en |=> !rq_irq);

  always_ff @(posedge clk) begin
    if (!rst) begin
      a_r6_bound: assert (wq_count <= WCW'(WQ_DEPTH) && rq_count <= RCW'(RQ_DEPTH));
    end
  end
endmodule

bind cq_ctrl cq_ctrl_chk #(.CMD_W(CMD_W), .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH)) u_chk (.*);

// File: tb/sim_cq_ctrl.sv
`timescale 1ns/1ps
module sim_cq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_queued = 0, cfg_run = 0, cfg_rd_irq_en = 0;
  logic [2:0] cfg_rd_thresh = '0;
  logic [3:0] cfg_wr_thresh = '0;
  logic ctl_wr_clear = 0, ctl_rd_clear = 0;
  logic host_wr_en = 0, host_rd_en = 0;
  logic [15:0] host_wr_word = '0;
  logic [7:0] host_rd_byte;
  logic host_rd_valid, eng_cmd_valid;
  logic [15:0] eng_cmd_word;
  logic eng_cmd_ready = 0, eng_ret_valid = 0;
  logic [7:0] eng_ret_byte = '0;
  logic [3:0] wq_count, rq_count;
  logic wq_full, wq_empty, rq_full, rq_empty, wq_ovf, rq_ovf, rq_unf, rq_irq, wq_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cq_ctrl u0 (.*);

  function automatic logic [15:0] wword(input int i);
    return 16'hA000 + 16'(i) * 16'h0111;
  endfunction

  function automatic logic [7:0] rbyte(input int i);
    return 8'h30 + 8'(i * 7);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] w);
    host_wr_en = 1; host_wr_word = w;
    step();
    host_wr_en = 0;
  endtask

  task automatic drain(input int n, input int first, input bit pace);
    int got = 0;
    bit prev_hold = 0;
    logic [15:0] prev_w = '0;
    for (int cyc = 0; cyc < 200 && got < n; cyc++) begin
      if (prev_hold) begin
        chk("R4 valid held while stalled", int'(eng_cmd_valid), 1);
        chk("R4 word held while stalled", int'(eng_cmd_word), int'(prev_w));
      end
      eng_cmd_ready = pace ? (cyc % 3 != 0) : 1'b1;
      if (eng_cmd_valid && eng_cmd_ready) begin
        chk("R4 dispatch order", int'(eng_cmd_word), int'(wword(first + got)));
        got++;
      end
      prev_hold = eng_cmd_valid && !eng_cmd_ready;
      prev_w = eng_cmd_word;
      step();
    end
    chk("R4 handshake count", got, n);
  endtask

  initial begin
    for (int i = 0; i < 50000 && !done; i++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(); step(); step();
    chk("R1 wq_count", int'(wq_count), 0);
    chk("R1 rq_count", int'(rq_count), 0);
    chk("R1 empties", int'({wq_empty, rq_empty}), 3);
    chk("R1 fulls", int'({wq_full, rq_full}), 0);
    chk("R1 sticky", int'({wq_ovf, rq_ovf, rq_unf}), 0);
    chk("R1 outputs", int'({eng_cmd_valid, host_rd_valid, rq_irq, wq_irq}), 0);
    rst = 0;

    // R3/R10: queued hold, write-threshold sweep at every count
    cfg_queued = 1; cfg_run = 0;
    for (int c = 0; c <= 8; c++) begin
      for (int t = 0; t <= 8; t++) begin
        cfg_wr_thresh = 4'(t);
        step();
        chk("R10 wq_irq", int'(wq_irq), int'(c <= t));
      end
      if (c < 8) begin
        host_write(wword(c));
        chk("R3 wq_count grows", int'(wq_count), c + 1);
        chk("R3 nothing offered", int'(eng_cmd_valid), 0);
      end
    end
    chk("R6 wq_full", int'(wq_full), 1);
    host_write(16'hBEEF);
    chk("R6 dropped write count", int'(wq_count), 8);
    chk("R6 wq_ovf set", int'(wq_ovf), 1);
    cfg_wr_thresh = '0;

    // R4: run with a stalling engine, order and hold
    cfg_run = 1;
    drain(8, 0, 1);
    eng_cmd_ready = 0;
    step(); step(); step();
    chk("R6 no extra word", int'(eng_cmd_valid), 0);
    chk("R6 queue drained", int'(wq_count), 0);
    chk("R6 ovf still sticky", int'(wq_ovf), 1);
    ctl_wr_clear = 1; step(); ctl_wr_clear = 0;
    chk("R11 wq_ovf cleared", int'(wq_ovf), 0);

    // R5: stop at a command boundary
    host_write(wword(8)); host_write(wword(9)); host_write(wword(10));
    step(); step();
    chk("R5 first offered", int'(eng_cmd_word), int'(wword(8)));
    chk("R5 queue behind", int'(wq_count), 2);
    cfg_run = 0;
    step(); step(); step(); step();
    chk("R5 offered word kept", int'(eng_cmd_valid), 1);
    chk("R5 offered word same", int'(eng_cmd_word), int'(wword(8)));
    eng_cmd_ready = 1;
    step(); step(); step();
    chk("R5 no next word while stopped", int'(eng_cmd_valid), 0);
    chk("R5 remaining stored", int'(wq_count), 2);
    cfg_run = 1;
    drain(2, 9, 0);
    eng_cmd_ready = 0;

    // R11: write clear keeps the offered word, beats a push
    host_write(wword(11)); host_write(wword(12)); host_write(wword(13));
    step(); step();
    chk("R11 pre-clear count", int'(wq_count), 2);
    ctl_wr_clear = 1; host_wr_en = 1; host_wr_word = 16'hDEAD;
    step();
    ctl_wr_clear = 0; host_wr_en = 0;
    chk("R11 write queue emptied", int'(wq_count), 0);
    chk("R11 offered word survives", int'(eng_cmd_valid), 1);
    chk("R11 offered word value", int'(eng_cmd_word), int'(wword(11)));
    eng_cmd_ready = 1;
    step(); step(); step();
    chk("R11 clear-cycle push dropped", int'(eng_cmd_valid), 0);

    // R2: direct mode ignores run
    cfg_queued = 0; cfg_run = 0;
    host_write(wword(14));
    step();
    chk("R2 direct valid", int'(eng_cmd_valid), 1);
    chk("R2 direct word", int'(eng_cmd_word), int'(wword(14)));
    step();
    chk("R2 accepted", int'(eng_cmd_valid), 0);
    eng_cmd_ready = 0;

    // R7/R9: read queue fill with full threshold sweep
    cfg_rd_irq_en = 1;
    for (int c = 0; c <= 8; c++) begin
      for (int t = 0; t <= 7; t++) begin
        cfg_rd_thresh = 3'(t);
        step();
        chk("R9 rq_irq", int'(rq_irq), int'(c >= t));
      end
      if (c < 8) begin
        eng_ret_valid = 1; eng_ret_byte = rbyte(c);
        step();
        eng_ret_valid = 0;
        chk("R7 rq_count", int'(rq_count), c + 1);
      end
    end
    chk("R7 rq_full", int'(rq_full), 1);
    eng_ret_valid = 1; eng_ret_byte = 8'hEE;
    step();
    eng_ret_valid = 0;
    chk("R8 push on full count", int'(rq_count), 8);
    chk("R8 rq_ovf", int'(rq_ovf), 1);
    cfg_rd_irq_en = 0; cfg_rd_thresh = '0;
    step(); step();
    chk("R9 disabled", int'(rq_irq), 0);
    for (int i = 0; i < 8; i++) begin
      host_rd_en = 1;
      step();
      host_rd_en = 0;
      chk("R7 pop valid", int'(host_rd_valid), 1);
      chk("R7 pop order", int'(host_rd_byte), int'(rbyte(i)));
    end
    host_rd_en = 1;
    step();
    host_rd_en = 0;
    chk("R8 empty pop no valid", int'(host_rd_valid), 0);
    chk("R8 rq_unf", int'(rq_unf), 1);

    // R11: read clear beats push and pop
    eng_ret_valid = 1; eng_ret_byte = 8'h11; step();
    eng_ret_byte = 8'h22; step();
    eng_ret_valid = 0;
    chk("R7 refill", int'(rq_count), 2);
    ctl_rd_clear = 1; eng_ret_valid = 1; host_rd_en = 1;
    step();
    ctl_rd_clear = 0; eng_ret_valid = 0; host_rd_en = 0;
    chk("R11 read queue emptied", int'(rq_count), 0);
    chk("R11 no pop result", int'(host_rd_valid), 0);
    chk("R11 read sticky cleared", int'({rq_ovf, rq_unf}), 0);
    chk("R11 rq_empty", int'(rq_empty), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule